// File: doc/BRIEF.md
# Serial Track Write Path with Check-Area Gap

This block turns host characters into a serial bit stream for a disk write head. The host places one character at a time in a holding register. At each character boundary that character moves to a shift register, and the holding register is released so the next one can be requested. Each character occupies one slot of nine bit-times: a sync bit of value 1 comes first, then eight data bits, most significant first. A bit-time strobe from the head clocking logic paces the slot. A digit counter tracks the position inside the slot.

Format recognition reports when the check area of the current record begins. The block then blanks one whole character slot: no sync bit and no data is driven. The reader uses this gap to locate the check area. During the gap the host sees no request, and the character waiting in the holding register stays put. After the gap that character, which is the last one of the record, is written. A lead flag clears when it moves into the shift register. When its final bit has gone out, a one-clock done pulse ends the write cycle. A missing host character at any transfer point raises a sticky underrun flag, and zeros are written in its place.

Top module: `wp_serial_writer`

## Requirements
- R1: While rst_n is low and on the first cycle after it is released, svc_req, wr_bit, wr_gate, gap_active, lead_active, underrun and done are all 0.
- R2: While writing, each bit_tick emits one bit-time, visible on wr_bit/wr_gate from the clock after the tick until the next tick. A slot is 9 bit-times: position 0 drives wr_bit=1 (sync), positions 1..8 drive the character's bits 7 down to 0, all with wr_gate=1.
- R3: host_load stores host_data in the holding register. svc_req is 1 exactly when a data slot is in progress (not gap, not last character) and the holding register is empty. It drops the clock after a load.
- R4: wr_start, accepted only when idle, moves the holding register into the shift register, sets lead_active and begins slot position 0. At the tick that ends each data slot with chk_area low, the holding register moves to the shift register and is freed.
- R5: If chk_area is 1 at the tick ending a data slot, the next 9 bit-times form a gap: gap_active is 1 for exactly those 9 bit-times, and wr_gate and wr_bit are 0 for each of them.
- R6: During the gap svc_req stays 0 and the holding register is not transferred, so the character held at gap entry is the one written after the gap.
- R7: At the tick that ends the gap, the held character moves to the shift register and lead_active falls to 0.
- R8: At the tick that ends the slot after the gap, done is 1 for exactly one clock and the block returns to idle. Each write cycle gives exactly one done pulse.
- R9: If a transfer is due (start or slot end outside the gap) and the holding register is empty, underrun becomes 1 and the slot carries data zeros. underrun stays 1 until the next accepted wr_start, which reloads it from the empty/full state at that moment.
- R10: On a clock without bit_tick, wr_bit and wr_gate do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-clock strobe per bit-time |
| wr_start | input | 1 | Begin a write cycle (honoured when idle) |
| chk_area | input | 1 | Check area begins after the current data slot |
| host_load | input | 1 | Load host_data into the holding register |
| host_data | input | DATA_W | Character from the host |
| svc_req | output | 1 | Request for the next character |
| wr_bit | output | 1 | Serial write data |
| wr_gate | output | 1 | Write enable for the current bit-time |
| gap_active | output | 1 | Blank check-area slot in progress |
| lead_active | output | 1 | Last character not yet transferred |
| underrun | output | 1 | Sticky missing-character flag |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The assertions assume the following about the inputs:
- bit_tick is a single-clock strobe.
- The host loads only while svc_req is high.
- Format recognition raises chk_area at most once per record and drops it once the gap has begun.
- wr_start pulses only while the block is idle.

The bench stays within these limits. Its host model answers svc_req only after an optional latency. It raises chk_area as it hands over the final character of a record, or from the start in the cases that test the gap early, and lowers it when gap_active appears. It changes the tick spacing from run to run, but every strobe stays one clock wide.

// File: rtl/wp_pkg.sv
// Package: shared types for the serial track write path.
// Assumes: one sync bit leads every character slot.
package wp_pkg;
    typedef enum logic [1:0] {
        WP_IDLE = 2'd0,
        WP_DATA = 2'd1,
        WP_GAP  = 2'd2,
        WP_LAST = 2'd3
    } wp_mode_e;
endpackage

// File: rtl/wp_digit_ring.sv
// Module: digit position counter for one character slot.
// Counts bit-times 0..SLOTS-1 and wraps; clr forces position 0.
// Assumes: clr and step are single-clock qualifiers from the controller.
module wp_digit_ring #(
    parameter int SLOTS = 9,
    localparam int PW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [PW-1:0] pos,
    output logic          at_last
);
    localparam logic [PW-1:0] LAST_POS = PW'(SLOTS - 1);

    assign at_last = (pos == LAST_POS);

    // Advance the slot position on each bit-time, wrapping after the last digit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (clr) begin
            pos <= '0;
        end else if (step) begin
            pos <= at_last ? '0 : pos + PW'(1);
        end
    end
endmodule

// File: rtl/wp_hold_reg.sv
// Module: host character holding register with a full flag.
// A load wins over a same-cycle take; take frees the register.
// Assumes: the host only loads while requested.
module wp_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              take,
    output logic [DATA_W-1:0] q,
    output logic              full
);
    // Capture host data and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            full <= 1'b0;
        end else if (load) begin
            q    <= load_data;
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/wp_serializer.sv
// Module: shift register and registered write-bus driver.
// On each tick drives sync or the next data bit (MSB first) when emit is set,
// otherwise blanks the bus. A load replaces the shift contents.
// Assumes: load never needs the value being shifted in the same cycle.
module wp_serializer #(
    parameter int   DATA_W     = 8,
    parameter logic SYNC_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              emit,
    input  logic              sync_slot,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              wr_bit,
    output logic              wr_gate
);
    logic [DATA_W-1:0] sr_q;

    // Drive the write bus once per bit-time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bit  <= 1'b0;
            wr_gate <= 1'b0;
        end else if (tick) begin
            wr_gate <= emit;
            wr_bit  <= emit & (sync_slot ? SYNC_LEVEL : sr_q[DATA_W-1]);
        end
    end

    // Load a new character or shift out the bit just driven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_data;
        end else if (tick && emit && !sync_slot) begin
            sr_q <= {sr_q[DATA_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/wp_serial_writer.sv
// Module: serial track write path with check-area sync-gap insertion (top).
// Sequences data slots, a blank gap slot at check-area entry, and the final
// character slot; requests host characters and flags underruns.
// Assumes: bit_tick is one clock wide; wr_start arrives only when idle.
module wp_serial_writer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_start,
    input  logic              chk_area,
    input  logic              host_load,
    input  logic [DATA_W-1:0] host_data,
    output logic              svc_req,
    output logic              wr_bit,
    output logic              wr_gate,
    output logic              gap_active,
    output logic              lead_active,
    output logic              underrun,
    output logic              done
);
    import wp_pkg::*;

    localparam int SLOTS = DATA_W + 1;
    localparam int PW    = $clog2(SLOTS);

    wp_mode_e          mode_q;
    logic [PW-1:0]     pos;
    logic              at_last;
    logic [DATA_W-1:0] hold_q;
    logic              hold_full;
    logic              tick_live;
    logic              slot_end;
    logic              start_go;
    logic              enter_gap;
    logic              xfer;
    logic              emit;

    // Decode slot events from mode, position and inputs.
    always_comb begin
        tick_live = bit_tick && (mode_q != WP_IDLE);
        slot_end  = tick_live && at_last;
        start_go  = wr_start && (mode_q == WP_IDLE);
        enter_gap = slot_end && (mode_q == WP_DATA) && chk_area;
        xfer      = start_go
                  || (slot_end && (mode_q == WP_DATA) && !chk_area)
                  || (slot_end && (mode_q == WP_GAP));
        emit      = (mode_q == WP_DATA) || (mode_q == WP_LAST);
    end

    assign svc_req     = (mode_q == WP_DATA) && !hold_full;
    assign gap_active  = (mode_q == WP_GAP);

    wp_digit_ring #(.SLOTS(SLOTS)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_go || enter_gap),
        .step    (tick_live),
        .pos     (pos),
        .at_last (at_last)
    );

    wp_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (host_load),
        .load_data (host_data),
        .take      (xfer),
        .q         (hold_q),
        .full      (hold_full)
    );

    wp_serializer #(.DATA_W(DATA_W), .SYNC_LEVEL(1'b1)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .emit      (emit),
        .sync_slot (pos == '0),
        .load      (xfer),
        .load_data (hold_full ? hold_q : '0),
        .wr_bit    (wr_bit),
        .wr_gate   (wr_gate)
    );

    // Mode sequencing: idle -> data slots -> gap -> last character -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= WP_IDLE;
        end else begin
            unique case (mode_q)
                WP_IDLE: if (start_go)  mode_q <= WP_DATA;
                WP_DATA: if (enter_gap) mode_q <= WP_GAP;
                WP_GAP:  if (slot_end)  mode_q <= WP_LAST;
                WP_LAST: if (slot_end)  mode_q <= WP_IDLE;
                default:                mode_q <= WP_IDLE;
            endcase
        end
    end

    // Lead flag: set at start, cleared when the last character is transferred.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_active <= 1'b0;
        end else if (start_go) begin
            lead_active <= 1'b1;
        end else if (slot_end && (mode_q == WP_GAP)) begin
            lead_active <= 1'b0;
        end
    end

    // Underrun: sticky per write cycle, set on a transfer from an empty register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underrun <= 1'b0;
        end else if (start_go) begin
            underrun <= !hold_full;
        end else if (xfer && !hold_full) begin
            underrun <= 1'b1;
        end
    end

    // Done: one-clock pulse at the end of the last character slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= slot_end && (mode_q == WP_LAST);
        end
    end
endmodule

// File: rtl/wp_serial_writer_chk.sv
// Module: property checker for the serial track write path, bound to the top.
module wp_serial_writer_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic wr_start,
    input logic svc_req,
    input logic wr_bit,
    input logic wr_gate,
    input logic gap_active,
    input logic lead_active,
    input logic underrun,
    input logic done
);
    AST_GAP_BLANKS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_active && bit_tick) |=> (!wr_gate && !wr_bit)); // R5
    AST_GAP_NO_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        gap_active |-> !svc_req); // R6
    AST_REQ_NEEDS_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> lead_active); // R3
    AST_LEAD_FALLS_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lead_active) |-> $past(gap_active)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AFTER_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!lead_active && !gap_active)); // R8
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !wr_start) |=> underrun); // R9
    AST_BUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && $past(rst_n)) |=> ($stable(wr_bit) && $stable(wr_gate))); // R10
endmodule

bind wp_serial_writer wp_serial_writer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .wr_start    (wr_start),
    .svc_req     (svc_req),
    .wr_bit      (wr_bit),
    .wr_gate     (wr_gate),
    .gap_active  (gap_active),
    .lead_active (lead_active),
    .underrun    (underrun),
    .done        (done)
);

// File: tb/wp_serial_writer_tb.sv
module wp_serial_writer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_start = 1'b0;
    logic       chk_area = 1'b0;
    logic       host_load = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       svc_req, wr_bit, wr_gate, gap_active, lead_active, underrun, done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    wp_serial_writer #(.DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_start(wr_start),
        .chk_area(chk_area), .host_load(host_load), .host_data(host_data),
        .svc_req(svc_req), .wr_bit(wr_bit), .wr_gate(wr_gate),
        .gap_active(gap_active), .lead_active(lead_active),
        .underrun(underrun), .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int       m_mode = 0;      // 0 idle, 1 data, 2 gap, 3 last
    int       m_cnt  = 0;      // bit-times already emitted in the slot
    bit [7:0] m_char = 0;
    bit [7:0] m_hold = 0;
    bit       m_full = 0;
    bit       m_bit = 0, m_gate = 0, m_lead = 0, m_under = 0, m_done = 0;

    always @(posedge clk) begin
        bit do_xfer;
        do_xfer = 0;
        m_done  = 0;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_char = 0; m_hold = 0; m_full = 0;
            m_bit = 0; m_gate = 0; m_lead = 0; m_under = 0;
        end else begin
            if (bit_tick) begin
                if (m_mode == 1 || m_mode == 3) begin
                    m_gate = 1;
                    m_bit  = (m_cnt == 0) ? 1'b1 : m_char[8 - m_cnt];
                end else begin
                    m_gate = 0;
                    m_bit  = 0;
                end
            end
            if (m_mode == 0) begin
                if (wr_start) begin
                    m_mode = 1; m_cnt = 0; m_lead = 1;
                    m_under = !m_full;
                    do_xfer = 1;
                end
            end else if (bit_tick) begin
                if (m_cnt == 8) begin
                    m_cnt = 0;
                    case (m_mode)
                        1: if (chk_area) m_mode = 2;
                           else begin do_xfer = 1; if (!m_full) m_under = 1; end
                        2: begin
                               do_xfer = 1; if (!m_full) m_under = 1;
                               m_lead = 0; m_mode = 3;
                           end
                        default: begin m_mode = 0; m_done = 1; end
                    endcase
                end else begin
                    m_cnt++;
                end
            end
            if (do_xfer) m_char = m_full ? m_hold : 8'h00;
            if (host_load) begin
                m_hold = host_data; m_full = 1;
            end else if (do_xfer) begin
                m_full = 0;
            end
        end
    end

    // ---------------- per-clock comparison ----------------
    int done_seen = 0;
    int gap_cyc   = 0;
    always @(negedge clk) begin
        chk("R1/R2 wr_bit",      wr_bit,      m_bit);
        chk("R2 wr_gate",        wr_gate,     m_gate);
        chk("R3 svc_req",        svc_req,     (m_mode == 1) && !m_full);
        chk("R5 gap_active",     gap_active,  m_mode == 2);
        chk("R7 lead_active",    lead_active, m_lead);
        chk("R9 underrun",       underrun,    m_under);
        chk("R8 done",           done,        m_done);
        if (done) done_seen++;
        if (gap_active) gap_cyc++;
    end

    // ---------------- bit-time strobe generator ----------------
    int tick_div = 0;
    int tcnt = 0;
    always @(negedge clk) begin
        if (tick_div == 0) begin
            bit_tick = 0;
        end else if (tcnt >= tick_div - 1) begin
            bit_tick = 1; tcnt = 0;
        end else begin
            bit_tick = 0; tcnt++;
        end
    end

    // ---------------- host responder ----------------
    int hq[$];
    bit host_en = 0;
    int host_lat = 0;
    int lat_cnt = 0;
    always @(negedge clk) begin
        if (host_en) begin
            host_load = 0;
            if (svc_req && hq.size() > 0) begin
                if (lat_cnt >= host_lat) begin
                    host_data = 8'(hq.pop_front());
                    host_load = 1;
                    lat_cnt = 0;
                    if (hq.size() == 0) chk_area = 1;
                end else begin
                    lat_cnt++;
                end
            end else begin
                lat_cnt = 0;
            end
            if (gap_active) chk_area = 0;
        end
    end

    // One write cycle: preload the first character, start, serve the rest.
    task automatic run_case(input int chars[$], input int div, input int lat,
                            input bit chk_early, input bit exp_under);
        int guard;
        tick_div = div; host_lat = lat; done_seen = 0; gap_cyc = 0;
        @(negedge clk);
        if (chars.size() > 0) begin
            host_data = 8'(chars[0]); host_load = 1;
            @(negedge clk);
            host_load = 0;
        end
        for (int i = 1; i < chars.size(); i++) hq.push_back(chars[i]);
        chk_area = chk_early || (chars.size() <= 1);
        wr_start = 1;
        @(negedge clk);
        wr_start = 0;
        host_en = 1;
        guard = 0;
        while (done_seen == 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk("R8 cycle finished", done_seen, 1);
        repeat (2 * div + 3) @(negedge clk);
        host_en = 0;
        chk("R8 single done pulse", done_seen, 1);
        chk("R5 gap length in clocks", gap_cyc, 9 * div);
        chk("R7 lead cleared at end", lead_active, 0);
        chk("R9 underrun result", underrun, exp_under);
        chk("R6 host queue drained", hq.size(), 0);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset gate",  wr_gate, 0);
        chk("R1 reset done",  done, 0);
        chk("R1 reset under", underrun, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release req",  svc_req, 0);
        chk("R1 after release lead", lead_active, 0);
        // R2 R3 R4: several data slots then gap and last character
        run_case('{8'hA5, 8'h3C, 8'hF1}, 3, 0, 1'b0, 1'b0);
        // R9: nothing supplied, gap follows the first slot
        run_case('{}, 2, 0, 1'b1, 1'b1);
        // R2 R4: back-to-back bit-times
        run_case('{8'hC3, 8'h96, 8'hE7, 8'h01}, 1, 0, 1'b0, 1'b0);
        // R6: check area right after the first slot, held character kept
        run_case('{8'h7E, 8'h81}, 2, 0, 1'b1, 1'b0);
        // R9: slow host misses a transfer
        run_case('{8'h11, 8'h22, 8'h33}, 2, 30, 1'b0, 1'b1);
        // R10: strobe stopped, bus static and block idle
        tick_div = 0;
        repeat (3) @(negedge clk);
        begin
            logic b0, g0;
            b0 = wr_bit; g0 = wr_gate;
            repeat (10) @(negedge clk);
            chk("R10 wr_bit static",  wr_bit,  b0);
            chk("R10 wr_gate static", wr_gate, g0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule